// File: doc/BRIEF.md
# Exact Bucketed Posit Summer

This block adds a stream of 8-bit posit values (zero exponent bits) with no rounding at any point. Each accepted value is decoded into a sign, a scale and a 6-bit integer significand. The signed significand is then added into a private integer register, or bucket, chosen by the scale. There are thirteen buckets, one for each scale from -6 to +6. No single wide register holds the running total.

When the producer marks its last value, the engine stops taking input and rebuilds the exact total bit by bit. It visits only the buckets between the lowest and the highest scale it saw. For each one it adds a running carry to the bucket, emits the low bit, and shifts the carry right arithmetically. A closing word then carries the leftover signed carry, the bit position that carry starts at, a not-a-real flag and an overflow flag. Once that word is taken, every bucket and bound is cleared and the next stream can begin.

The result is fixed point with the least significant bit worth 2^-11. Emitted bit `res_pos` has weight 2^res_pos in those units. The full value is the sum of the emitted bits plus `fin_carry` times 2^`fin_pos`.

Top module: `psum_engine`

## Requirements
- R1: A posit p is decoded as follows. Sign s is bit 7. Magnitude a is p, or its two's complement when s is 1. Regime k is m-1 for a run of m ones, or -m for a run of m zeros, counted from bit 6 of a. The up-to-5 bits after the regime terminator are the fraction f, left-aligned. The value contributes (-1)^s·(32+f)·2^(k+6) to the total, and the reconstructed total equals the exact sum of all contributions.
- R2: The pattern 0x00 contributes nothing to the total or to the bucket range.
- R3: The pattern 0x80 contributes nothing to the total and sets `fin_nar`, which stays set until the closing word is accepted.
- R4: While accumulating, `in_ready` is high on every cycle, so one posit is accepted per clock.
- R5: After the last input, `res_valid` is high for exactly hi-lo+1 consecutive cycles, where lo and hi are the lowest and highest bucket index (k+6) written. `res_pos` runs lo, lo+1, ..., hi.
- R6: After the bit stream, `fin_valid` rises. `fin_pos` is hi+1, or 0 if no bucket was written. `fin_carry` is the signed upper part of the total, and `fin_neg` is high exactly when the total is negative. These stay stable until `fin_ready`.
- R7: `in_ready` is low from the cycle after the last input until the cycle after the closing word is accepted.
- R8: Accepting the closing word clears all buckets, both bounds, the term count and both flags, so the next stream sums from zero.
- R9: `fin_ovf` is high when more than MAX_TERMS posits were accepted in the stream.
- R10: A stream with no nonzero, non-NaR value produces no bit cycles and a closing word with `fin_carry` 0 and `fin_pos` 0.
- R11: After reset, `in_ready` is high and `res_valid` and `fin_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input posit valid |
| in_ready | output | 1 | Engine accepts a posit |
| in_posit | input | 8 | Posit value, zero exponent bits |
| in_last | input | 1 | Marks the final posit of a stream |
| res_valid | output | 1 | Result bit valid |
| res_bit | output | 1 | Result bit |
| res_pos | output | 4 | Bit position of res_bit |
| fin_valid | output | 1 | Closing word valid |
| fin_ready | input | 1 | Closing word accepted |
| fin_carry | output | CW (16) | Signed upper part of the total |
| fin_pos | output | 5 | Bit position where fin_carry starts |
| fin_neg | output | 1 | Total is negative |
| fin_nar | output | 1 | A NaR value was seen |
| fin_ovf | output | 1 | Term count exceeded MAX_TERMS |

## Verification
The assertions check several properties on every cycle. Input is never ready while bits are flowing. Bit positions climb by one per cycle. The bucket bounds stay ordered. The closing word holds still until it is taken, and the NaR flag is sticky. Accepting the word clears state, and the walker's carry never exceeds the bucket width. Only the bench's scenarios can show that the rebuilt total equals the exact sum. They also show that zero and NaR values leave it untouched, that the visited range matches the scales supplied, and that overflow and the empty stream are reported correctly.

// File: rtl/psum_pkg.sv
package psum_pkg;
    localparam int PBITS     = 8;
    localparam int SCALE_MAX = PBITS - 2;
    localparam int NBUCK     = 2 * SCALE_MAX + 1;
    localparam int IDX_W     = $clog2(NBUCK);
    localparam int FRAC_W    = PBITS - 3;
    localparam int MANT_W    = FRAC_W + 1;

    typedef struct packed {
        logic              is_zero;
        logic              is_nar;
        logic              neg;
        logic [IDX_W-1:0]  idx;
        logic [MANT_W-1:0] mant;
    } term_t;

    typedef enum logic [1:0] {ST_ACC, ST_WALK, ST_FIN} phase_e;

    function automatic term_t decode_posit(input logic [PBITS-1:0] p);
        term_t             t;
        logic [PBITS-1:0]  a;
        logic [PBITS-2:0]  body;
        logic [PBITS-2:0]  sh;
        logic              r0;
        logic              stop;
        int                m;
        int                kk;
        t         = '0;
        t.is_zero = (p == '0);
        t.is_nar  = (p == {1'b1, {(PBITS-1){1'b0}}});
        t.neg     = p[PBITS-1];
        a         = t.neg ? (~p + 1'b1) : p;
        body      = a[PBITS-2:0];
        r0        = body[PBITS-2];
        m         = 0;
        stop      = 1'b0;
        for (int i = PBITS - 2; i >= 0; i--) begin
            if (!stop && body[i] == r0) m++;
            else stop = 1'b1;
        end
        kk     = r0 ? (m - 1) : -m;
        sh     = body << (m + 1);
        t.mant = {1'b1, sh[PBITS-2 -: FRAC_W]};
        t.idx  = IDX_W'(kk + SCALE_MAX);
        if (t.is_zero || t.is_nar) begin
            t.neg  = 1'b0;
            t.idx  = '0;
            t.mant = '0;
        end
        return t;
    endfunction
endpackage

// File: rtl/psum_decode.sv
module psum_decode
    import psum_pkg::*;
(
    input  logic [PBITS-1:0] posit,
    output term_t            term
);
    always_comb begin
        term = decode_posit(posit);
    end

    always_comb begin
        if (!term.is_zero && !term.is_nar) begin
            AST_SCALE_RANGE: assert (int'(term.idx) < NBUCK && term.mant[MANT_W-1]); // R1
        end
    end
endmodule

// File: rtl/psum_bucket_bank.sv
module psum_bucket_bank #(
    parameter int NB    = 13,
    parameter int IDX_W = 4,
    parameter int BW    = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 add_en,
    input  logic [IDX_W-1:0]     add_idx,
    input  logic signed [BW-1:0] add_val,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic signed [BW-1:0] rd_val,
    output logic [IDX_W-1:0]     lo_idx,
    output logic [IDX_W-1:0]     hi_idx,
    output logic                 occupied,
    output logic [IDX_W-1:0]     lo_nxt,
    output logic [IDX_W-1:0]     hi_nxt,
    output logic                 occ_nxt
);
    logic signed [BW-1:0] bucket [NB];

    for (genvar g = 0; g < NB; g++) begin : g_bucket
        always_ff @(posedge clk) begin
            if (rst || clr) bucket[g] <= '0;
            else if (add_en && int'(add_idx) == g) bucket[g] <= bucket[g] + add_val;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NB; i++) begin
            if (int'(rd_idx) == i) rd_val = bucket[i];
        end
    end

    always_comb begin
        lo_nxt  = lo_idx;
        hi_nxt  = hi_idx;
        occ_nxt = occupied | add_en;
        if (add_en) begin
            if (!occupied || add_idx < lo_idx) lo_nxt = add_idx;
            if (!occupied || add_idx > hi_idx) hi_nxt = add_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lo_idx   <= IDX_W'(NB - 1);
            hi_idx   <= '0;
            occupied <= 1'b0;
        end else begin
            lo_idx   <= lo_nxt;
            hi_idx   <= hi_nxt;
            occupied <= occ_nxt;
        end
    end

    AST_BOUNDS_ORDER: assert property (@(posedge clk) disable iff (rst)
        occupied |-> (lo_idx <= hi_idx)); // R5
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr |=> !occupied); // R8
endmodule

// File: rtl/psum_walker.sv
module psum_walker #(
    parameter int BW = 15,
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 step,
    input  logic signed [BW-1:0] bucket,
    output logic                 bit_o,
    output logic signed [CW-1:0] carry_o
);
    logic signed [CW:0] t;

    always_comb begin
        t     = (CW+1)'(carry_o) + (CW+1)'(bucket);
        bit_o = t[0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) carry_o <= '0;
        else if (step)  carry_o <= CW'(t >>> 1);
    end

    AST_CARRY_BOUND: assert property (@(posedge clk) disable iff (rst)
        step |=> (carry_o[CW-1] == carry_o[BW-1])); // R1
endmodule

// File: rtl/psum_engine.sv
module psum_engine
    import psum_pkg::*;
#(
    parameter int MAX_TERMS = 256,
    parameter int BW        = MANT_W + 1 + $clog2(MAX_TERMS),
    parameter int CW        = BW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [PBITS-1:0]     in_posit,
    input  logic                 in_last,
    output logic                 res_valid,
    output logic                 res_bit,
    output logic [IDX_W-1:0]     res_pos,
    output logic                 fin_valid,
    input  logic                 fin_ready,
    output logic signed [CW-1:0] fin_carry,
    output logic [IDX_W:0]       fin_pos,
    output logic                 fin_neg,
    output logic                 fin_nar,
    output logic                 fin_ovf
);
    localparam int CNT_W = $clog2(MAX_TERMS + 2);

    phase_e               state;
    term_t                term;
    logic                 acc, add_en, clr, step;
    logic signed [BW-1:0] add_val, rd_val;
    logic [IDX_W-1:0]     walk_idx, lo_idx, hi_idx, lo_nxt, hi_nxt;
    logic                 occupied, occ_nxt;
    logic [IDX_W:0]       fin_pos_q;
    logic                 nar_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 walk_bit;
    logic signed [CW-1:0] carry;

    psum_decode u_dec (
        .posit (in_posit),
        .term  (term)
    );

    always_comb begin
        in_ready = (state == ST_ACC);
        acc      = in_valid && in_ready;
        add_en   = acc && !term.is_zero && !term.is_nar;
        add_val  = term.neg ? -BW'(term.mant) : BW'(term.mant);
        clr      = (state == ST_FIN) && fin_ready;
        step     = (state == ST_WALK);
    end

    psum_bucket_bank #(.NB(NBUCK), .IDX_W(IDX_W), .BW(BW)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .add_en   (add_en),
        .add_idx  (term.idx),
        .add_val  (add_val),
        .rd_idx   (walk_idx),
        .rd_val   (rd_val),
        .lo_idx   (lo_idx),
        .hi_idx   (hi_idx),
        .occupied (occupied),
        .lo_nxt   (lo_nxt),
        .hi_nxt   (hi_nxt),
        .occ_nxt  (occ_nxt)
    );

    psum_walker #(.BW(BW), .CW(CW)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .step    (step),
        .bucket  (rd_val),
        .bit_o   (walk_bit),
        .carry_o (carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_ACC;
            walk_idx  <= '0;
            fin_pos_q <= '0;
        end else begin
            unique case (state)
                ST_ACC: begin
                    if (acc && in_last) begin
                        if (occ_nxt) begin
                            state    <= ST_WALK;
                            walk_idx <= lo_nxt;
                        end else begin
                            state     <= ST_FIN;
                            fin_pos_q <= '0;
                        end
                    end
                end
                ST_WALK: begin
                    if (walk_idx == hi_idx) begin
                        state     <= ST_FIN;
                        fin_pos_q <= (IDX_W+1)'(hi_idx) + 1'b1;
                    end else begin
                        walk_idx <= walk_idx + 1'b1;
                    end
                end
                ST_FIN: begin
                    if (fin_ready) state <= ST_ACC;
                end
                default: state <= ST_ACC;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            nar_q <= 1'b0;
            cnt_q <= '0;
        end else if (acc) begin
            if (term.is_nar) nar_q <= 1'b1;
            if (int'(cnt_q) <= MAX_TERMS) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        res_valid = (state == ST_WALK);
        res_bit   = walk_bit;
        res_pos   = walk_idx;
        fin_valid = (state == ST_FIN);
        fin_carry = carry;
        fin_pos   = fin_pos_q;
        fin_neg   = carry[CW-1];
        fin_nar   = nar_q;
        fin_ovf   = (int'(cnt_q) > MAX_TERMS);
    end

    AST_READY_PHASE: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && in_ready) && !(fin_valid && in_ready)); // R7
    AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(res_valid)) |-> (res_pos == $past(res_pos) + 1'b1)); // R5
    AST_FIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fin_valid && !fin_ready) |=> (fin_valid && $stable(fin_carry) && $stable(fin_pos))); // R6
    AST_NAR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fin_nar && !(fin_valid && fin_ready)) |=> fin_nar); // R3
    AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (rst)
        (fin_valid && fin_ready) |=> (!fin_nar && !fin_ovf && in_ready)); // R8
endmodule

// File: tb/sim_psum_engine.sv
module sim_psum_engine;
    localparam int MAXT = 256;
    localparam int BW   = 6 + 1 + $clog2(MAXT);
    localparam int CW   = BW + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_last = 1'b0, fin_ready = 1'b0;
    logic [7:0] in_posit = '0;
    logic in_ready, res_valid, res_bit, fin_valid, fin_neg, fin_nar, fin_ovf;
    logic [3:0] res_pos;
    logic signed [CW-1:0] fin_carry;
    logic [4:0] fin_pos;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] stim [$];

    always #5 clk = ~clk;

    psum_engine #(.MAX_TERMS(MAXT)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_posit(in_posit), .in_last(in_last), .res_valid(res_valid),
        .res_bit(res_bit), .res_pos(res_pos), .fin_valid(fin_valid),
        .fin_ready(fin_ready), .fin_carry(fin_carry), .fin_pos(fin_pos),
        .fin_neg(fin_neg), .fin_nar(fin_nar), .fin_ovf(fin_ovf)
    );

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic void ref_term(input logic [7:0] p, output bit v,
                                     output longint val, output int idx);
        logic [7:0] mag;
        bit lead;
        int run, b, k, fb, frac, mant;
        v = 0; val = 0; idx = 0;
        if (p == 8'h00 || p == 8'h80) return;
        mag  = p[7] ? 8'(-p) : p;
        lead = mag[6];
        run  = 1;
        b    = 5;
        while (b >= 0 && mag[b] == lead) begin run++; b--; end
        k    = lead ? run - 1 : -run;
        fb   = (b > 0) ? b : 0;
        frac = int'(mag) & ((1 << fb) - 1);
        mant = 32 + (frac << (5 - fb));
        val  = longint'(mant) <<< (k + 6);
        if (p[7]) val = -val;
        idx  = k + 6;
        v    = 1;
    endfunction

    task automatic run_seq(input string tag);
        longint exp_sum = 0, rec = 0, val;
        int lo = 99, hi = -1, idx, n, exp_pos, nbits = 0;
        bit v, exp_nar = 0, order_bad = 0, ready_bad = 0;
        n = stim.size();
        for (int i = 0; i < n; i++) begin
            ref_term(stim[i], v, val, idx);
            if (v) begin
                exp_sum += val;
                if (idx < lo) lo = idx;
                if (idx > hi) hi = idx;
            end
            if (stim[i] == 8'h80) exp_nar = 1;
            @(negedge clk);
            chk(in_ready === 1'b1, {"R4 ready during accumulation ", tag}, longint'(in_ready), 1);
            in_valid = 1'b1;
            in_posit = stim[i];
            in_last  = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        exp_pos  = lo;
        for (int c = 0; c < 64 && !fin_valid; c++) begin
            if (in_ready) ready_bad = 1;
            if (res_valid) begin
                if (int'(res_pos) != exp_pos) order_bad = 1;
                rec += longint'(res_bit) <<< res_pos;
                exp_pos++;
                nbits++;
            end
            @(negedge clk);
        end
        chk(fin_valid === 1'b1, {"R6 closing word appears ", tag}, longint'(fin_valid), 1);
        chk(!ready_bad && !in_ready, {"R7 ready low in phase 2 ", tag}, longint'(ready_bad), 0);
        chk(!order_bad, {"R5 bit positions ascend from lo ", tag}, longint'(order_bad), 0);
        chk(nbits == ((hi >= 0) ? hi - lo + 1 : 0), {"R5/R10 bit cycle count ", tag},
            nbits, (hi >= 0) ? hi - lo + 1 : 0);
        chk(int'(fin_pos) == ((hi >= 0) ? hi + 1 : 0), {"R6 fin_pos ", tag},
            fin_pos, (hi >= 0) ? hi + 1 : 0);
        if (n <= MAXT) begin
            rec += longint'($signed(fin_carry)) <<< fin_pos;
            chk(rec == exp_sum, {"R1 exact total ", tag}, rec, exp_sum);
            chk(fin_neg == (exp_sum < 0), {"R6 sign ", tag}, longint'(fin_neg), longint'(exp_sum < 0));
        end
        chk(fin_nar == exp_nar, {"R3 nar flag ", tag}, longint'(fin_nar), longint'(exp_nar));
        chk(fin_ovf == (n > MAXT), {"R9 overflow flag ", tag}, longint'(fin_ovf), longint'(n > MAXT));
        @(negedge clk);
        chk(fin_valid && !in_ready, {"R7 held until accepted ", tag}, longint'(in_ready), 0);
        fin_ready = 1'b1;
        @(negedge clk);
        fin_ready = 1'b0;
        chk(in_ready && !fin_valid, {"R8 back to accumulate ", tag}, longint'(in_ready), 1);
        stim.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int seed_junk;
        seed_junk = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready && !res_valid && !fin_valid, "R11 reset state", longint'(in_ready), 1);

        stim.push_back(8'h40);
        run_seq("one");
        stim.push_back(8'h40); stim.push_back(8'hC0);
        run_seq("cancel");
        stim.push_back(8'h7F); stim.push_back(8'h01); stim.push_back(8'h81); stim.push_back(8'h5B);
        run_seq("extremes");
        stim.push_back(8'h00); stim.push_back(8'h33); stim.push_back(8'h00); stim.push_back(8'h00);
        run_seq("R2 zeros mixed");
        stim.push_back(8'h00); stim.push_back(8'h00);
        run_seq("R10 empty");
        stim.push_back(8'h22); stim.push_back(8'h80); stim.push_back(8'h9D);
        run_seq("R3 nar");
        stim.push_back(8'h80);
        run_seq("R3 nar only");
        for (int i = 0; i < 300; i++) stim.push_back(8'h01);
        run_seq("R9 overflow");
        stim.push_back(8'h65);
        run_seq("R8 after overflow");
        for (int i = 0; i < MAXT; i++) stim.push_back(8'h7F);
        run_seq("full positive");
        for (int r = 0; r < 40; r++) begin
            int len;
            len = 1 + int'($urandom % 48);
            for (int i = 0; i < len; i++) begin
                logic [7:0] x;
                x = 8'($urandom);
                if ($urandom % 8 == 0) x = 8'h00;
                stim.push_back(x);
            end
            run_seq("random");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule